// File: doc/BRIEF.md
# Address-Linked Test Data Generator

This block produces 64-bit test data whose value is a pure function of the bus address. The word does not depend on a free-running state. A sender and a receiver that share the pattern select and the seed therefore derive identical data for any address, in any order and from any starting offset. One address per clock can be presented. The generated word appears on the next clock, and back-to-back addresses give back-to-back words.

The same expected word feeds an in-line checker. In compare mode, received data and its byte enables arrive with the address. Only the enabled bytes are compared, and the verdict is registered one cycle later. An error log keeps three things until a clear pulse: a sticky error bit, the full address of the first failing access, and a saturating count of all mismatching accesses.

Five pattern families are available: a walking one, a walking zero, an alternating all-zeros/all-ones pattern that stresses ground bounce, a counting pattern and a seeded pseudo-random pattern. Transfers can be 64 or 32 bits wide.

Top module: `addr_pattern_engine`

## Requirements
- R1: After reset, gen_vld, gen_data, mismatch, err_sticky, first_err_addr and err_count are all zero.
- R2: When addr_vld is high at a clock edge, gen_vld is high after that edge and gen_data holds the word for that address. This holds on every clock, so consecutive addresses give consecutive words with no gap.
- R3: The pattern index q is addr[22:3], a 20-bit value. Address bits above 22 and bits 1:0 never change the data. In 64-bit mode addr[2] does not change the data either.
- R4: With pat_sel = 0 (walking one), the word has exactly one bit set, at position q[5:0].
- R5: With pat_sel = 1 (walking zero), the word is all ones except a single zero at position q[5:0].
- R6: With pat_sel = 2 (bounce), the word is all zeros when q is even and all ones when q is odd.
- R7: With pat_sel = 3 (count-up), bits 31:0 hold 2q and bits 63:32 hold 2q+1. Each 32-bit half therefore carries its own dword number.
- R8: With pat_sel = 4 (pseudo-random), the word is built as follows. Start with v = seed XOR q, where q is zero-extended to 64 bits. Then apply three rounds of v ^= v<<13; v ^= v>>7; v ^= v<<17. pat_sel values 5 to 7 give an all-zero word.
- R9: With xfer32 = 1, gen_data is {32'h0, h}. Here h is bits 63:32 of the pattern word when addr[2] = 1, and bits 31:0 otherwise.
- R10: Each bit i of in_be is active high and enables byte in_data[8i+7:8i]. With cmp_en and addr_vld high, mismatch is high on the next cycle if any enabled byte differs from the same byte of the word that R2 and R9 define. In 32-bit mode only in_be[3:0] count. In all other cases mismatch is low on the next cycle.
- R11: On the first mismatch, err_sticky rises and first_err_addr takes the full failing address in the same cycle as mismatch. Both then hold through later mismatches. A clr pulse zeroes err_sticky, first_err_addr and err_count on the next cycle, and clr wins over a mismatch in the same cycle.
- R12: err_count rises by one per mismatching access and saturates at 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_sel | input | 3 | Pattern family select |
| seed | input | 64 | Seed for the pseudo-random family |
| xfer32 | input | 1 | 1 = 32-bit transfer on lanes 3:0 |
| cmp_en | input | 1 | Compare received data |
| clr | input | 1 | Clear error log |
| addr_vld | input | 1 | Address (and data in compare mode) valid |
| addr | input | 32 | Byte address |
| in_data | input | 64 | Received data |
| in_be | input | 8 | Byte enables, active high |
| gen_vld | output | 1 | gen_data valid |
| gen_data | output | 64 | Generated word |
| mismatch | output | 1 | Compare failure for the previous access |
| err_sticky | output | 1 | At least one mismatch since clear |
| first_err_addr | output | 32 | Address of first mismatch |
| err_count | output | 16 | Saturating mismatch count |

## Verification
The bench sends indices that wrap the 64-bit walking position. A design that uses the wrong modulus or the wrong index bits would put the bit in the wrong place. It also aliases addresses above bit 22 and in the low bits, which a design that keys on the wrong bits would not treat as identical. The compare tests corrupt a disabled byte and the upper lanes of a 32-bit transfer, where a design that ignores enables would flag a false mismatch. They also corrupt one enabled byte, which a design that drops lanes would miss. The error-log tests give a second failing address, issue a clear in the same cycle as a mismatch, and drive more than 65535 failures. A design that overwrites the first address, lets the mismatch win over the clear, or wraps the counter would report wrong values.

// File: rtl/apg_pkg.sv
package apg_pkg;
  localparam int DATA_W      = 64;
  localparam int LANES       = DATA_W / 8;
  localparam int IDX_W       = 20;
  localparam int IDX_LSB     = 3;
  localparam int IDX_HI      = IDX_LSB + IDX_W - 1;
  localparam int PRNG_ROUNDS = 3;

  typedef enum logic [2:0] {
    PAT_WALK1  = 3'd0,
    PAT_WALK0  = 3'd1,
    PAT_BOUNCE = 3'd2,
    PAT_COUNT  = 3'd3,
    PAT_PRNG   = 3'd4
  } pat_e;

  function automatic logic [DATA_W-1:0] scramble(logic [IDX_W-1:0] q,
                                                 logic [DATA_W-1:0] seed);
    logic [DATA_W-1:0] v;
    v = seed ^ {{(DATA_W-IDX_W){1'b0}}, q};
    for (int r = 0; r < PRNG_ROUNDS; r++) begin
      v = v ^ (v << 13);
      v = v ^ (v >> 7);
      v = v ^ (v << 17);
    end
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] pattern_word(logic [2:0] sel,
                                                     logic [IDX_W-1:0] q,
                                                     logic [DATA_W-1:0] seed);
    logic [DATA_W-1:0] one_hot;
    one_hot = {{(DATA_W-1){1'b0}}, 1'b1} << q[5:0];
    case (sel)
      PAT_WALK1:  return one_hot;
      PAT_WALK0:  return ~one_hot;
      PAT_BOUNCE: return {DATA_W{q[0]}};
      PAT_COUNT:  return {{(31-IDX_W){1'b0}}, q, 1'b1, {(31-IDX_W){1'b0}}, q, 1'b0};
      PAT_PRNG:   return scramble(q, seed);
      default:    return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_view(logic [DATA_W-1:0] w,
                                                  logic x32, logic upper);
    if (!x32) return w;
    return {32'h0, upper ? w[63:32] : w[31:0]};
  endfunction
endpackage

// File: rtl/apg_word_gen.sv
module apg_word_gen
  import apg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_vld,
  input  logic [2:0]        pat_sel,
  input  logic [DATA_W-1:0] seed,
  input  logic              xfer32,
  input  logic [IDX_W-1:0]  q_idx,
  input  logic              half_sel,
  output logic [DATA_W-1:0] exp_word,
  output logic              gen_vld,
  output logic [DATA_W-1:0] gen_data
);
  logic [2:0] sel_q;
  logic       x32_q;

  assign exp_word = lane_view(pattern_word(pat_sel, q_idx, seed), xfer32, half_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_vld  <= 1'b0;
      gen_data <= '0;
      sel_q    <= '0;
      x32_q    <= 1'b0;
    end else begin
      gen_vld <= addr_vld;
      if (addr_vld) begin
        gen_data <= exp_word;
        sel_q    <= pat_sel;
        x32_q    <= xfer32;
      end
    end
  end

  // R4
  walk1_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_vld && sel_q == PAT_WALK1 && !x32_q) |-> $countones(gen_data) == 1);

  // R9
  upper_zero_x32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_vld && x32_q) |-> gen_data[63:32] == 32'h0);
endmodule

// File: rtl/apg_byte_cmp.sv
module apg_byte_cmp
  import apg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic              xfer32,
  input  logic [DATA_W-1:0] exp_word,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  in_be,
  output logic              hit,
  output logic              mismatch
);
  logic [LANES-1:0] lane_diff;
  logic [LANES-1:0] lane_en;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_diff[i] = exp_word[8*i +: 8] != in_data[8*i +: 8];
    if (i < LANES/2) begin : g_low
      assign lane_en[i] = in_be[i];
    end else begin : g_high
      assign lane_en[i] = in_be[i] & ~xfer32;
    end
  end

  assign hit = chk_en & |(lane_diff & lane_en);

  always_ff @(posedge clk) begin
    if (!rst_n) mismatch <= 1'b0;
    else        mismatch <= hit;
  end

  // R10
  idle_no_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !mismatch);
endmodule

// File: rtl/apg_err_log.sv
module apg_err_log #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hit,
  input  logic [ADDR_W-1:0] addr,
  output logic              err_sticky,
  output logic [ADDR_W-1:0] first_err_addr,
  output logic [CNT_W-1:0]  err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      err_sticky     <= 1'b0;
      first_err_addr <= '0;
      err_count      <= '0;
    end else if (hit) begin
      err_sticky <= 1'b1;
      if (!err_sticky) first_err_addr <= addr;
      if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
    end
  end

  // R11
  first_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !clr) |=> (err_sticky && $stable(first_err_addr)));

  // R11
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!err_sticky && err_count == '0));

  // R12
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && err_count == CNT_MAX) |=> err_count == CNT_MAX);
endmodule

// File: rtl/addr_pattern_engine.sv
module addr_pattern_engine
  import apg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        pat_sel,
  input  logic [63:0]       seed,
  input  logic              xfer32,
  input  logic              cmp_en,
  input  logic              clr,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       in_data,
  input  logic [7:0]        in_be,
  output logic              gen_vld,
  output logic [63:0]       gen_data,
  output logic              mismatch,
  output logic              err_sticky,
  output logic [ADDR_W-1:0] first_err_addr,
  output logic [CNT_W-1:0]  err_count
);
  logic [IDX_W-1:0]  q_idx;
  logic              half_sel;
  logic [DATA_W-1:0] exp_word;
  logic              chk_en;
  logic              hit;

  assign q_idx    = addr[IDX_HI:IDX_LSB];
  assign half_sel = addr[IDX_LSB-1];
  assign chk_en   = addr_vld & cmp_en;

  apg_word_gen u_gen (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .pat_sel(pat_sel),
    .seed(seed), .xfer32(xfer32), .q_idx(q_idx), .half_sel(half_sel),
    .exp_word(exp_word), .gen_vld(gen_vld), .gen_data(gen_data)
  );

  apg_byte_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .xfer32(xfer32),
    .exp_word(exp_word), .in_data(in_data), .in_be(in_be),
    .hit(hit), .mismatch(mismatch)
  );

  apg_err_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hit(hit), .addr(addr),
    .err_sticky(err_sticky), .first_err_addr(first_err_addr),
    .err_count(err_count)
  );

  // R2
  gen_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> gen_vld);

  // R2
  gen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> !gen_vld);

  // R11
  sticky_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !$past(clr)) |-> err_sticky);
endmodule

// File: tb/addr_pattern_engine_test.sv
module addr_pattern_engine_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  pat_sel = 0;
  logic [63:0] seed = 0;
  logic        xfer32 = 0, cmp_en = 0, clr = 0, addr_vld = 0;
  logic [31:0] addr = 0;
  logic [63:0] in_data = 0;
  logic [7:0]  in_be = 0;
  logic        gen_vld, mismatch, err_sticky;
  logic [63:0] gen_data;
  logic [31:0] first_err_addr;
  logic [15:0] err_count;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_pattern_engine uut (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .seed(seed), .xfer32(xfer32),
    .cmp_en(cmp_en), .clr(clr), .addr_vld(addr_vld), .addr(addr),
    .in_data(in_data), .in_be(in_be), .gen_vld(gen_vld), .gen_data(gen_data),
    .mismatch(mismatch), .err_sticky(err_sticky),
    .first_err_addr(first_err_addr), .err_count(err_count)
  );

  function automatic logic [63:0] ref_word(logic [2:0] s, logic [31:0] a,
                                           logic [63:0] sd, logic x32);
    logic [19:0] q;
    logic [63:0] w;
    logic [31:0] lo, hi;
    q = a[22:3];
    case (s)
      3'd0: w = 64'd1 << q[5:0];
      3'd1: w = ~(64'd1 << q[5:0]);
      3'd2: w = q[0] ? '1 : '0;
      3'd3: begin lo = 32'(q) * 2; hi = lo + 1; w = {hi, lo}; end
      3'd4: begin
        w = sd ^ 64'(q);
        repeat (3) begin
          w = w ^ (w << 13);
          w = w ^ (w >> 7);
          w = w ^ (w << 17);
        end
      end
      default: w = 0;
    endcase
    if (x32) w = a[2] ? {32'h0, w[63:32]} : {32'h0, w[31:0]};
    return w;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one access at a negedge, sample the registered result at the next negedge.
  task automatic access(logic [2:0] s, logic [31:0] a, logic x32, logic c,
                        logic [63:0] d, logic [7:0] be);
    pat_sel = s; addr = a; xfer32 = x32; cmp_en = c;
    in_data = d; in_be = be; addr_vld = 1;
    @(negedge clk);
    addr_vld = 0; cmp_en = 0;
  endtask

  task automatic pulse_clr();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 gen_vld", 64'(gen_vld), 0);
    chk("R1 gen_data", gen_data, 0);
    chk("R1 mismatch", 64'(mismatch), 0);
    chk("R1 sticky", 64'(err_sticky), 0);
    chk("R1 first addr", 64'(first_err_addr), 0);
    chk("R1 count", 64'(err_count), 0);
  endtask

  task automatic t_walk();
    access(0, 32'h0, 0, 0, 0, 0);
    chk("R4 walk1 q0", gen_data, 64'h1);
    chk("R2 gen_vld", 64'(gen_vld), 1);
    @(negedge clk);
    chk("R2 gen_vld idle", 64'(gen_vld), 0);
    access(0, 32'd5 << 3, 0, 0, 0, 0);
    chk("R4 walk1 q5", gen_data, 64'h20);
    access(0, 32'd70 << 3, 0, 0, 0, 0);
    chk("R4 walk1 q70 wraps", gen_data, 64'h40);
    access(1, 32'd70 << 3, 0, 0, 0, 0);
    chk("R5 walk0 q70", gen_data, ~64'h40);
    access(1, 32'd63 << 3, 0, 0, 0, 0);
    chk("R5 walk0 q63", gen_data, 64'h7FFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_alias();
    logic [63:0] base;
    access(4, 32'h0012_3450, 0, 0, 0, 0);
    base = gen_data;
    chk("R8 prng base", base, ref_word(4, 32'h0012_3450, seed, 0));
    access(4, 32'hFF92_3457, 0, 0, 0, 0);
    chk("R3 upper and low bits ignored", gen_data, base);
  endtask

  task automatic t_families();
    access(2, 32'd6 << 3, 0, 0, 0, 0);
    chk("R6 bounce even", gen_data, 64'h0);
    access(2, 32'd7 << 3, 0, 0, 0, 0);
    chk("R6 bounce odd", gen_data, '1);
    access(3, 32'd9 << 3, 0, 0, 0, 0);
    chk("R7 count q9", gen_data, {32'd19, 32'd18});
    access(3, 32'h007F_FFF8, 0, 0, 0, 0);
    chk("R7 count top index", gen_data, {32'h001F_FFFF, 32'h001F_FFFE});
    access(4, 32'h0000_0008, 0, 0, 0, 0);
    chk("R8 prng q1", gen_data, ref_word(4, 32'h8, seed, 0));
    access(4, 32'h0000_0000, 0, 0, 0, 0);
    chk("R8 prng q0", gen_data, ref_word(4, 32'h0, seed, 0));
    access(6, 32'h0000_0040, 0, 0, 0, 0);
    chk("R8 unused code zero", gen_data, 0);
  endtask

  task automatic t_x32();
    access(3, 32'h14, 1, 0, 0, 0);
    chk("R9 x32 upper half", gen_data, 64'd5);
    access(3, 32'h10, 1, 0, 0, 0);
    chk("R9 x32 lower half", gen_data, 64'd4);
  endtask

  task automatic t_stream();
    logic [31:0] prev;
    for (int i = 0; i < 5; i++) begin
      pat_sel = 3; xfer32 = 0; addr = 32'(i * 40 + 8); addr_vld = 1;
      if (i > 0) begin
        chk("R2 back-to-back vld", 64'(gen_vld), 1);
        chk("R2 back-to-back data", gen_data, ref_word(3, prev, seed, 0));
      end
      prev = addr;
      @(negedge clk);
    end
    addr_vld = 0;
    chk("R2 last stream word", gen_data, ref_word(3, prev, seed, 0));
  endtask

  task automatic t_compare();
    logic [63:0] e;
    pulse_clr();
    e = ref_word(4, 32'h200, seed, 0);
    access(4, 32'h200, 0, 1, e, 8'hFF);
    chk("R10 match", 64'(mismatch), 0);
    access(4, 32'h200, 0, 1, e ^ (64'hFF << 40), 8'hDF);
    chk("R10 disabled byte ignored", 64'(mismatch), 0);
    e = ref_word(3, 32'h14, seed, 1);
    access(3, 32'h14, 1, 1, e ^ 64'hAB00_0000_0000_0000, 8'hFF);
    chk("R10 x32 upper lanes ignored", 64'(mismatch), 0);
    chk("R10 nothing logged", 64'(err_count), 0);
    e = ref_word(4, 32'h200, seed, 0);
    access(4, 32'h200, 0, 1, e ^ (64'h01 << 40), 8'hFF);
    chk("R10 enabled byte flagged", 64'(mismatch), 1);
    access(4, 32'h200, 0, 0, e ^ (64'h01 << 40), 8'hFF);
    chk("R10 no compare without cmp_en", 64'(mismatch), 0);
  endtask

  task automatic t_log();
    pulse_clr();
    access(2, 32'h0000_1238, 0, 1, 64'h0, 8'h01);
    chk("R11 sticky", 64'(err_sticky), 1);
    chk("R11 first addr", 64'(first_err_addr), 64'h1238);
    access(2, 32'h0ABC_0010, 0, 1, 64'h1, 8'h01);
    chk("R11 first addr held", 64'(first_err_addr), 64'h1238);
    chk("R12 count two", 64'(err_count), 2);
    clr = 1;
    access(2, 32'h0000_0018, 0, 1, 64'h0, 8'h01);
    clr = 0;
    chk("R11 clr beats mismatch sticky", 64'(err_sticky), 0);
    chk("R11 clr beats mismatch count", 64'(err_count), 0);
    chk("R11 clr zeroes addr", 64'(first_err_addr), 0);
  endtask

  task automatic t_sat();
    pulse_clr();
    pat_sel = 2; xfer32 = 0; cmp_en = 1; addr = 32'h8; in_data = 0; in_be = 8'hFF;
    addr_vld = 1;
    repeat (65540) @(negedge clk);
    addr_vld = 0; cmp_en = 0;
    chk("R12 saturated", 64'(err_count), 64'hFFFF);
    chk("R12 sticky after many", 64'(err_sticky), 1);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    seed = 64'hC3A5_9E37_0F1E_2D4B;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_walk();
    t_alias();
    t_families();
    t_x32();
    t_stream();
    t_compare();
    t_log();
    t_sat();
    finish_up();
  end
endmodule